// File: doc/BRIEF.md
# Protected-Configuration Watchdog Timer

This block guards a system against a stalled or runaway program. It counts strobes from a slow, free-running tick. Software must restart the count with a kick strobe before the selected timeout runs out. If the count runs out while the timer is enabled, the block raises a one-cycle system-reset request and sets a sticky watchdog-reset flag.

The timeout is 2^(BASE_SHIFT+sel) ticks, where `sel` is a 4-bit select. With BASE_SHIFT = 11 and a tick of about 128 kHz, select codes 0 to 9 give timeouts from about 16 ms up to about 8 s.

The enable bit and the select field are protected. Software first writes an unlock value. It then has a short window of cycles in which to write the new setting; writes made at any other time leave those fields unchanged. While the watchdog-reset flag is set, the timer cannot be turned off. A power-on reset starts the block disabled. Any other reset brings it back enabled at the shortest timeout.

Top module: `wdog_guard`

## Requirements
- R1: While `por` is high, and in the cycle after it, the block is disabled. The select is 0, the flag is clear, the unlock window is closed, `ctrl_rd` reads 0x00 and `sys_rst_req` is low.
- R2: A `rst` pulse without `por` leaves the timer enabled with select 0 and the unlock window closed. The flag keeps its value, so `ctrl_rd` reads 0x08, or 0x88 when the flag was set.
- R3: The `ctrl_rd` layout is: bit 7 flag, bit 5 select bit 3, bit 4 window open, bit 3 enable, bits 2:0 select bits 2:0. A control write with bit 4 and bit 3 both set opens the unlock window for WIN_CYC cycles, and bit 4 reads 1 while it is open. The next control write inside the window loads the enable bit from bit 3 and the select from {bit 5, bits 2:0}. That write also closes the window. A write in the 4th cycle after the unlock is still accepted.
- R4: A control write made with no unlock, or made WIN_CYC+1 or more cycles after the unlock, leaves the enable and the select unchanged. The window is closed again by then.
- R5: A select code from 10 to 15 in an accepted write leaves the previous select unchanged.
- R6: While the timer is enabled, the tick strobe that completes 2^(BASE_SHIFT+sel) ticks since the last restart raises `sys_rst_req` for exactly one cycle. The count then starts over.
- R7: A kick restarts the count. A kick that arrives in the same cycle as the expiring tick wins, and no reset is requested.
- R8: An expiry sets the flag. A status write of 0 clears it, as does a power-on reset. A status write of 1 has no effect.
- R9: While the flag is set, the enable bit stays 1, even after an unlock followed by a write of all zeros.
- R10: While the timer is disabled, ticks never raise `sys_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Other system reset, synchronous, active high |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| kick | input | 1 | Restart strobe for the timeout count |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| stat_we | input | 1 | Status (flag) write strobe |
| stat_wdata | input | 1 | Status write data; 0 clears the flag |
| ctrl_rd | output | 8 | Control and status readback |
| wd_flag | output | 1 | Watchdog-reset flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two events can land in the same cycle: a software kick and the tick that would complete the timeout. The bench first brings the count up to one tick short of the limit. It then drives kick and tick together on one clock edge. It checks that no reset request appears and that the count starts over, so that a full timeout period of further ticks is needed before the next request. A second overlap is also provoked: a write that lands in the last open cycle of the unlock window, and one that lands in the first cycle after the window has closed. The bench judges each by reading back the control value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW         = 8;
  localparam int EN_BIT     = 3;
  localparam int CE_BIT     = 4;
  localparam int SEL_HI_BIT = 5;
  localparam int FLAG_BIT   = 7;
  localparam int SEL_W      = 4;
  localparam int SEL_MAX    = 9;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } wd_cfg_t;

  function automatic logic [SEL_W-1:0] sel_of(input logic [DW-1:0] d);
    return {d[SEL_HI_BIT], d[2:0]};
  endfunction
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic          clk,
  input  logic          por,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          win_open,
  output logic          apply
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [WW-1:0] win_q;
  logic          unlock_hit;

  assign unlock_hit = wr_en && wr_data[CE_BIT] && wr_data[EN_BIT];
  assign win_open   = (win_q != '0);
  assign apply      = wr_en && win_open && !unlock_hit;

  always_ff @(posedge clk) begin
    if (por || rst)          win_q <= '0;
    else if (unlock_hit)     win_q <= WW'(WIN_CYC);
    else if (apply)          win_q <= '0;
    else if (win_q != '0)    win_q <= win_q - 1'b1;
  end

  // R4
  win_decay_chk: assert property (@(posedge clk) disable iff (por || rst)
    (win_q != '0 && !wr_en) |=> (win_q == $past(win_q) - 1'b1));
  // R3
  win_arm_chk: assert property (@(posedge clk) disable iff (por || rst)
    unlock_hit |=> win_open);
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          por,
  input  logic          rst,
  input  logic          apply,
  input  logic [DW-1:0] wr_data,
  input  logic          expire,
  input  logic          stat_we,
  input  logic          stat_wdata,
  output wd_cfg_t       cfg,
  output logic          flag
);
  logic [SEL_W-1:0] new_sel;
  logic             sel_ok;

  assign new_sel = sel_of(wr_data);
  assign sel_ok  = (new_sel <= SEL_W'(SEL_MAX));

  always_ff @(posedge clk) begin
    if (por) begin
      cfg.en  <= 1'b0;
      cfg.sel <= '0;
      flag    <= 1'b0;
    end else if (rst) begin
      cfg.en  <= 1'b1;
      cfg.sel <= '0;
    end else begin
      if (apply) begin
        cfg.en <= wr_data[EN_BIT] | flag | expire;
        if (sel_ok) cfg.sel <= new_sel;
      end
      if (expire)                       flag <= 1'b1;
      else if (stat_we && !stat_wdata)  flag <= 1'b0;
    end
  end

  // R9
  flag_forces_en_chk: assert property (@(posedge clk) disable iff (por)
    flag |-> cfg.en);
  // R5
  reserved_sel_chk: assert property (@(posedge clk) disable iff (por || rst)
    (apply && !sel_ok) |=> $stable(cfg.sel));
  // R1
  por_state_chk: assert property (@(posedge clk)
    por |=> (!cfg.en && !flag && cfg.sel == '0));
  // R2
  sys_rst_state_chk: assert property (@(posedge clk)
    (rst && !por) |=> (cfg.en && cfg.sel == '0));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 11
) (
  input  logic    clk,
  input  logic    por,
  input  logic    rst,
  input  logic    tick,
  input  logic    kick,
  input  wd_cfg_t cfg,
  output logic    expire,
  output logic    req
);
  localparam int CW = BASE_SHIFT + SEL_MAX + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = (CW'(1) << (BASE_SHIFT + int'(cfg.sel))) - 1'b1;
  assign expire = cfg.en && tick && !kick && (cnt_q >= lim_m1);

  always_ff @(posedge clk) begin
    if (por || rst) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      req <= expire;
      if (kick || !cfg.en || expire) cnt_q <= '0;
      else if (tick)                 cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  req_needs_en_chk: assert property (@(posedge clk) disable iff (por || rst)
    req |-> $past(cfg.en));
  // R7
  kick_blocks_chk: assert property (@(posedge clk) disable iff (por || rst)
    kick |=> !req);
  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (por || rst)
    req |=> !req);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 11,
  parameter int WIN_CYC    = 4
) (
  input  logic          clk,
  input  logic          por,
  input  logic          rst,
  input  logic          tick,
  input  logic          kick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_we,
  input  logic          stat_wdata,
  output logic [DW-1:0] ctrl_rd,
  output logic          wd_flag,
  output logic          sys_rst_req
);
  wd_cfg_t cfg;
  logic    win_open, apply, expire, flag;

  wdog_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .win_open(win_open), .apply(apply)
  );

  wdog_cfg u_cfg (
    .clk(clk), .por(por), .rst(rst), .apply(apply), .wr_data(wr_data),
    .expire(expire), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .cfg(cfg), .flag(flag)
  );

  wdog_count #(.BASE_SHIFT(BASE_SHIFT)) u_count (
    .clk(clk), .por(por), .rst(rst), .tick(tick), .kick(kick), .cfg(cfg),
    .expire(expire), .req(sys_rst_req)
  );

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[2:0]        = cfg.sel[2:0];
    ctrl_rd[SEL_HI_BIT] = cfg.sel[3];
    ctrl_rd[EN_BIT]     = cfg.en;
    ctrl_rd[CE_BIT]     = win_open;
    ctrl_rd[FLAG_BIT]   = flag;
  end

  assign wd_flag = flag;

  // R8
  flag_on_expiry_chk: assert property (@(posedge clk) disable iff (por || rst)
    sys_rst_req |-> wd_flag);
endmodule

// File: tb/wdog_guard_test.sv
module wdog_guard_test;
  logic       clk = 1'b0;
  logic       por = 1'b1, rst = 1'b0, tick = 1'b0, kick = 1'b0;
  logic       wr_en = 1'b0, stat_we = 1'b0, stat_wdata = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_rd;
  logic       wd_flag, sys_rst_req;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wdog_guard #(.BASE_SHIFT(2), .WIN_CYC(4)) uut (
    .clk(clk), .por(por), .rst(rst), .tick(tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .ctrl_rd(ctrl_rd), .wd_flag(wd_flag),
    .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic swr(input logic v);
    stat_we = 1'b1; stat_wdata = v;
    @(negedge clk);
    stat_we = 1'b0;
  endtask

  task automatic pulse_tick(input logic with_kick);
    tick = 1'b1; kick = with_kick;
    @(negedge clk);
    tick = 1'b0; kick = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic test_por();
    por = 1'b1; idle(3); por = 1'b0; idle(1);
    check("R1 ctrl after por", ctrl_rd, 8'h00);
    check("R1 req after por", {7'd0, sys_rst_req}, 8'h00);
  endtask

  task automatic test_unlock();
    wr(8'h18);
    check("R3 window reads open", ctrl_rd, 8'h10);
    wr(8'h0B);
    check("R3 accepted write", ctrl_rd, 8'h0B);
    wr(8'h0D);
    check("R4 write without unlock", ctrl_rd, 8'h0B);
    wr(8'h18); idle(4); wr(8'h0C);
    check("R4 late write ignored", ctrl_rd, 8'h0B);
    wr(8'h18); wr(8'h29);
    check("R3 select code 9 position", ctrl_rd, 8'h29);
    wr(8'h18); wr(8'h2A);
    check("R5 reserved select kept", ctrl_rd, 8'h29);
    wr(8'h18); idle(3); wr(8'h08);
    check("R3 write in last window cycle", ctrl_rd, 8'h08);
  endtask

  task automatic test_timeout();
    do_kick();
    for (int i = 0; i < 3; i++) begin
      pulse_tick(1'b0);
      check("R6 no early request sel0", {7'd0, sys_rst_req}, 8'h00);
    end
    pulse_tick(1'b0);
    check("R6 request at 4th tick", {7'd0, sys_rst_req}, 8'h01);
    check("R8 flag set on expiry", {7'd0, wd_flag}, 8'h01);
    idle(1);
    check("R6 request lasts one cycle", {7'd0, sys_rst_req}, 8'h00);
    wr(8'h18); wr(8'h09);
    check("R3 select 1 with flag", ctrl_rd, 8'h89);
    do_kick();
    for (int i = 0; i < 7; i++) pulse_tick(1'b0);
    check("R6 no request after 7 ticks sel1", {7'd0, sys_rst_req}, 8'h00);
    pulse_tick(1'b0);
    check("R6 request at 8th tick sel1", {7'd0, sys_rst_req}, 8'h01);
  endtask

  task automatic test_kick();
    wr(8'h18); wr(8'h08);
    check("R3 back to select 0", ctrl_rd, 8'h88);
    do_kick();
    for (int i = 0; i < 3; i++) pulse_tick(1'b0);
    do_kick();
    for (int i = 0; i < 3; i++) pulse_tick(1'b0);
    check("R7 kick restarted count", {7'd0, sys_rst_req}, 8'h00);
    pulse_tick(1'b1);
    check("R7 kick beats expiring tick", {7'd0, sys_rst_req}, 8'h00);
    for (int i = 0; i < 3; i++) pulse_tick(1'b0);
    check("R7 count restarted by same-cycle kick", {7'd0, sys_rst_req}, 8'h00);
    pulse_tick(1'b0);
    check("R7 full period after same-cycle kick", {7'd0, sys_rst_req}, 8'h01);
  endtask

  task automatic test_flag();
    logic seen;
    swr(1'b1);
    check("R8 status write 1 no effect", {7'd0, wd_flag}, 8'h01);
    wr(8'h18); wr(8'h00);
    check("R9 disable blocked by flag", ctrl_rd, 8'h88);
    swr(1'b0);
    check("R8 status write 0 clears", ctrl_rd, 8'h08);
    wr(8'h18); wr(8'h00);
    check("R9 disable after clear", ctrl_rd, 8'h00);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      pulse_tick(1'b0);
      seen = seen | sys_rst_req;
    end
    check("R10 no request while disabled", {7'd0, seen}, 8'h00);
  endtask

  task automatic test_resets();
    wr(8'h18); wr(8'h08);
    do_kick();
    for (int i = 0; i < 4; i++) pulse_tick(1'b0);
    check("R8 flag set again", {7'd0, wd_flag}, 8'h01);
    wr(8'h18);
    rst = 1'b1; idle(1); rst = 1'b0;
    check("R2 system reset keeps flag, armed sel0", ctrl_rd, 8'h88);
    swr(1'b0);
    wr(8'h18); wr(8'h2A & 8'hF7);
    check("R5 reserved code with disable", ctrl_rd, 8'h00);
    rst = 1'b1; idle(1); rst = 1'b0;
    check("R2 system reset re-arms", ctrl_rd, 8'h08);
    swr(1'b1);
    por = 1'b1; idle(1); por = 1'b0;
    check("R1 power-on clears all", ctrl_rd, 8'h00);
    check("R1 flag low", {7'd0, wd_flag}, 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: bench timed out, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_por();
    test_unlock();
    test_timeout();
    test_kick();
    test_flag();
    test_resets();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule